// File: doc/BRIEF.md
# Machine-Check Bank Error Logger

This block holds a small set of machine-check reporting banks and decides what happens to each error that is injected into them. Every bank keeps a control word, a status word, an address word and an auxiliary (misc) word, all 64 bits wide. Three global words sit beside the banks. The capability word comes in on a port. The global control and global status words are held inside the block.

An injection request carries a bank number, a status word, a global status word, an address, a misc word and an unconditional flag. The block first validates the request and then applies one of several outcomes. It can log the error and raise a machine-check interrupt. It can request a reset instead. It can ignore the request or reject it. It can also log a corrected error without interrupting. Each outcome is a one-cycle pulse on its own output, one cycle after the strobe.

A configuration write port programs the global and per-bank control words. A combinational read port exposes every register so the state can be inspected.

Top module: `mc_bank_logger`

## Requirements
- R1: The number of usable banks is the low byte of `cap_i`, further limited by the storage parameter NUM_BANKS (default 4). A request is rejected (`rejected_o`) when that byte is 0 or when the bank number is not below the count. A rejected request changes no state.
- R2: A request whose status bit 63 (valid) is clear is rejected, and no state changes.
- R3: A valid request is ignored (`ignored_o`) with no state change when all three of these hold: status bit 55 (action required) is clear, `inj_uncond_i` is low, and bit 2 of the held global status (in-progress) is set.
- R4: An uncorrected request (status bit 61 set) that would otherwise proceed is dropped, pulsing `ignored_o` with no state change, in either of two cases. The first is when `cap_i` bit 8 is set and global control is not all ones. The second is when the target bank's control word is not all ones. When `cap_i` bit 8 is clear, global control has no effect.
- R5: An uncorrected request that passes R4 pulses `reset_req_o` and changes no state when `mce_en_i` is low or the held in-progress bit is set.
- R6: Otherwise an uncorrected request writes the bank's address, misc and status and the global status, then pulses `mce_irq_o`. The written status is the request status with bit 62 (overflow) also set when the bank's previous status had bit 63 set.
- R7: A corrected request (bit 61 clear) aimed at a bank whose previous status is not a valid uncorrected error overwrites that bank's address, misc and status. The written status gains bit 62 when the previous status was valid. Global status is unchanged and `logged_o` pulses.
- R8: A corrected request aimed at a bank that holds a valid uncorrected error only sets bit 62 of the existing status. Address and misc are kept, and `logged_o` pulses.
- R9: After reset every bank control word and the global control word read all ones. Bank status, address, misc and global status read 0.
- R10: Exactly one of the five outcome outputs pulses for one cycle, in the cycle after each `inj_v_i` strobe. None pulses in a cycle that follows no strobe.
- R11: When `cfg_we_i` is high, `cfg_data_i` is written to global control if `cfg_global_i` is high, and otherwise to the control word of bank `cfg_bank_i` (out-of-range banks are ignored). `rd_data_o` shows the register chosen by `rd_sel_i`, read against bank `rd_bank_i` where a bank is involved: 0 bank control, 1 bank status, 2 bank address, 3 bank misc, 4 global control, 5 global status, 6 capability, 7 zero. A bank number out of range reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_i | input | 64 | Capability word: bank count in bits 7:0, control-present in bit 8 |
| mce_en_i | input | 1 | Machine-check enable from the system control state |
| cfg_we_i | input | 1 | Control-word write strobe |
| cfg_global_i | input | 1 | 1 writes global control, 0 writes a bank control word |
| cfg_bank_i | input | 8 | Bank selected for a control write |
| cfg_data_i | input | 64 | Control write data |
| inj_v_i | input | 1 | Injection strobe |
| inj_bank_i | input | 8 | Target bank |
| inj_status_i | input | 64 | Status word of the error |
| inj_gstat_i | input | 64 | Global status to record with an uncorrected error |
| inj_addr_i | input | 64 | Address word |
| inj_misc_i | input | 64 | Misc word |
| inj_uncond_i | input | 1 | Deliver even while an earlier error is in progress |
| rd_sel_i | input | 3 | Register selector for reads |
| rd_bank_i | input | 8 | Bank selector for reads |
| rd_data_o | output | 64 | Read data |
| mce_irq_o | output | 1 | Machine-check interrupt pulse |
| reset_req_o | output | 1 | Reset request pulse |
| ignored_o | output | 1 | Request ignored or dropped |
| rejected_o | output | 1 | Request rejected as invalid |
| logged_o | output | 1 | Corrected error logged without interrupt |

## Verification
On every cycle the assertions check several properties. At most one outcome output may be active, and no outcome may appear without a preceding strobe. Requests lacking the valid bit, or arriving with an empty capability byte, must be rejected. Each interrupt must carry the global status that came with it. An overflow-only update must keep a bank's address word. Only the bench's scenarios can show the rest. These include the order of precedence among ignore, drop, reset and log, and the overflow marking across a sequence of errors into the same bank. They also include the effect of the control words and the reset values read back through the port.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int ST_VAL_BIT  = 63;
  localparam int ST_OVER_BIT = 62;
  localparam int ST_UC_BIT   = 61;
  localparam int ST_AR_BIT   = 55;
  localparam int GS_BUSY_BIT = 2;
  localparam int CAP_CTLP_BIT = 8;

  typedef enum logic [2:0] {
    OC_NONE     = 3'd0,
    OC_IRQ      = 3'd1,
    OC_RESET    = 3'd2,
    OC_IGNORED  = 3'd3,
    OC_REJECTED = 3'd4,
    OC_LOGGED   = 3'd5
  } outcome_e;
endpackage

// File: rtl/mcb_rst_sync.sv
module mcb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          req_v_i,
  input  logic          in_range_i,
  input  logic [7:0]    bank_i,
  input  logic [DW-1:0] status_i,
  input  logic          uncond_i,
  input  logic          mce_en_i,
  input  logic [DW-1:0] cap_i,
  input  logic [DW-1:0] gctl_i,
  input  logic [DW-1:0] gstat_i,
  input  logic [DW-1:0] bank_ctl_i,
  input  logic [DW-1:0] bank_old_i,
  output outcome_e      outcome_o,
  output logic          log_we_o,
  output logic          gstat_we_o,
  output logic          over_we_o,
  output logic [DW-1:0] new_status_o
);
  logic bank_ok;
  logic old_valid;
  logic old_uc;
  logic gctl_block;
  logic bank_block;

  assign bank_ok    = in_range_i && (bank_i < cap_i[7:0]);
  assign old_valid  = bank_old_i[ST_VAL_BIT];
  assign old_uc     = bank_old_i[ST_UC_BIT];
  assign gctl_block = cap_i[CAP_CTLP_BIT] && (gctl_i != {DW{1'b1}});
  assign bank_block = (bank_ctl_i != {DW{1'b1}});

  always_comb begin
    outcome_o    = OC_NONE;
    log_we_o     = 1'b0;
    gstat_we_o   = 1'b0;
    over_we_o    = 1'b0;
    new_status_o = status_i;
    if (req_v_i) begin
      if ((cap_i == '0) || !bank_ok || !status_i[ST_VAL_BIT]) begin
        outcome_o = OC_REJECTED;
      end else if (!status_i[ST_AR_BIT] && !uncond_i && gstat_i[GS_BUSY_BIT]) begin
        outcome_o = OC_IGNORED;
      end else if (status_i[ST_UC_BIT]) begin
        if (gctl_block || bank_block) begin
          outcome_o = OC_IGNORED;
        end else if (!mce_en_i || gstat_i[GS_BUSY_BIT]) begin
          outcome_o = OC_RESET;
        end else begin
          new_status_o[ST_OVER_BIT] = status_i[ST_OVER_BIT] | old_valid;
          log_we_o   = 1'b1;
          gstat_we_o = 1'b1;
          outcome_o  = OC_IRQ;
        end
      end else if (!old_valid || !old_uc) begin
        new_status_o[ST_OVER_BIT] = status_i[ST_OVER_BIT] | old_valid;
        log_we_o  = 1'b1;
        outcome_o = OC_LOGGED;
      end else begin
        over_we_o = 1'b1;
        outcome_o = OC_LOGGED;
      end
    end
  end
endmodule

// File: rtl/mcb_bank_array.sv
module mcb_bank_array
  import mcb_pkg::*;
#(
  parameter int NB = 4,
  parameter int DW = 64,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [BW-1:0] cfg_idx_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic          log_we_i,
  input  logic          over_we_i,
  input  logic [BW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_status_i,
  input  logic [DW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_misc_i,
  output logic [DW-1:0] ctl_o    [NB],
  output logic [DW-1:0] status_o [NB],
  output logic [DW-1:0] addr_o   [NB],
  output logic [DW-1:0] misc_o   [NB]
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [DW-1:0] ctl_q, ctl_d;
    logic [DW-1:0] st_q, st_d;
    logic [DW-1:0] ad_q, ad_d;
    logic [DW-1:0] mi_q, mi_d;
    logic          hit;
    logic          cfg_hit;

    assign hit     = (wr_idx_i == BW'(g));
    assign cfg_hit = cfg_we_i && (cfg_idx_i == BW'(g));

    always_comb begin
      ctl_d = ctl_q;
      st_d  = st_q;
      ad_d  = ad_q;
      mi_d  = mi_q;
      if (cfg_hit) ctl_d = cfg_data_i;
      if (log_we_i && hit) begin
        st_d = wr_status_i;
        ad_d = wr_addr_i;
        mi_d = wr_misc_i;
      end else if (over_we_i && hit) begin
        st_d[ST_OVER_BIT] = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q <= {DW{1'b1}};
        st_q  <= '0;
        ad_q  <= '0;
        mi_q  <= '0;
      end else begin
        ctl_q <= ctl_d;
        st_q  <= st_d;
        ad_q  <= ad_d;
        mi_q  <= mi_d;
      end
    end

    AST_OVER_KEEPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (over_we_i && hit) |=> (st_q[ST_OVER_BIT] && (ad_q == $past(ad_q)))); // R8

    assign ctl_o[g]    = ctl_q;
    assign status_o[g] = st_q;
    assign addr_o[g]   = ad_q;
    assign misc_o[g]   = mi_q;
  end
endmodule

// File: rtl/mc_bank_logger.sv
module mc_bank_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DW        = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] cap_i,
  input  logic          mce_en_i,
  input  logic          cfg_we_i,
  input  logic          cfg_global_i,
  input  logic [7:0]    cfg_bank_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic          inj_v_i,
  input  logic [7:0]    inj_bank_i,
  input  logic [DW-1:0] inj_status_i,
  input  logic [DW-1:0] inj_gstat_i,
  input  logic [DW-1:0] inj_addr_i,
  input  logic [DW-1:0] inj_misc_i,
  input  logic          inj_uncond_i,
  input  logic [2:0]    rd_sel_i,
  input  logic [7:0]    rd_bank_i,
  output logic [DW-1:0] rd_data_o,
  output logic          mce_irq_o,
  output logic          reset_req_o,
  output logic          ignored_o,
  output logic          rejected_o,
  output logic          logged_o
);
  localparam int         BW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [7:0] NB_L = 8'(NUM_BANKS);

  logic rst_n;

  mcb_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  logic [DW-1:0] bank_ctl  [NUM_BANKS];
  logic [DW-1:0] bank_st   [NUM_BANKS];
  logic [DW-1:0] bank_addr [NUM_BANKS];
  logic [DW-1:0] bank_misc [NUM_BANKS];

  logic [DW-1:0] gctl_q, gctl_d;
  logic [DW-1:0] gstat_q, gstat_d;
  outcome_e      oc_q, oc_d;

  logic          inj_in_range;
  logic [BW-1:0] inj_idx;
  logic [DW-1:0] sel_ctl;
  logic [DW-1:0] sel_old;
  logic          log_we, gstat_we, over_we;
  logic [DW-1:0] new_status;

  assign inj_in_range = (inj_bank_i < NB_L);
  assign inj_idx      = inj_bank_i[BW-1:0];
  assign sel_ctl      = inj_in_range ? bank_ctl[inj_idx] : '0;
  assign sel_old      = inj_in_range ? bank_st[inj_idx]  : '0;

  mcb_decide #(.DW(DW)) u_decide (
    .req_v_i      (inj_v_i),
    .in_range_i   (inj_in_range),
    .bank_i       (inj_bank_i),
    .status_i     (inj_status_i),
    .uncond_i     (inj_uncond_i),
    .mce_en_i     (mce_en_i),
    .cap_i        (cap_i),
    .gctl_i       (gctl_q),
    .gstat_i      (gstat_q),
    .bank_ctl_i   (sel_ctl),
    .bank_old_i   (sel_old),
    .outcome_o    (oc_d),
    .log_we_o     (log_we),
    .gstat_we_o   (gstat_we),
    .over_we_o    (over_we),
    .new_status_o (new_status)
  );

  logic cfg_bank_we;
  assign cfg_bank_we = cfg_we_i && !cfg_global_i && (cfg_bank_i < NB_L);

  mcb_bank_array #(.NB(NUM_BANKS), .DW(DW)) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_bank_we),
    .cfg_idx_i   (cfg_bank_i[BW-1:0]),
    .cfg_data_i  (cfg_data_i),
    .log_we_i    (log_we),
    .over_we_i   (over_we),
    .wr_idx_i    (inj_idx),
    .wr_status_i (new_status),
    .wr_addr_i   (inj_addr_i),
    .wr_misc_i   (inj_misc_i),
    .ctl_o       (bank_ctl),
    .status_o    (bank_st),
    .addr_o      (bank_addr),
    .misc_o      (bank_misc)
  );

  always_comb begin
    gctl_d  = gctl_q;
    gstat_d = gstat_q;
    if (cfg_we_i && cfg_global_i) gctl_d = cfg_data_i;
    if (gstat_we) gstat_d = inj_gstat_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q  <= {DW{1'b1}};
      gstat_q <= '0;
      oc_q    <= OC_NONE;
    end else begin
      gctl_q  <= gctl_d;
      gstat_q <= gstat_d;
      oc_q    <= oc_d;
    end
  end

  assign mce_irq_o   = (oc_q == OC_IRQ);
  assign reset_req_o = (oc_q == OC_RESET);
  assign ignored_o   = (oc_q == OC_IGNORED);
  assign rejected_o  = (oc_q == OC_REJECTED);
  assign logged_o    = (oc_q == OC_LOGGED);

  logic          rd_in_range;
  logic [BW-1:0] rd_idx;
  assign rd_in_range = (rd_bank_i < NB_L);
  assign rd_idx      = rd_bank_i[BW-1:0];

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      3'd0: if (rd_in_range) rd_data_o = bank_ctl[rd_idx];
      3'd1: if (rd_in_range) rd_data_o = bank_st[rd_idx];
      3'd2: if (rd_in_range) rd_data_o = bank_addr[rd_idx];
      3'd3: if (rd_in_range) rd_data_o = bank_misc[rd_idx];
      3'd4: rd_data_o = gctl_q;
      3'd5: rd_data_o = gstat_q;
      3'd6: rd_data_o = cap_i;
      default: rd_data_o = '0;
    endcase
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({mce_irq_o, reset_req_o, ignored_o, rejected_o, logged_o})); // R10
  AST_QUIET_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !inj_v_i |=> !(mce_irq_o || reset_req_o || ignored_o || rejected_o || logged_o)); // R10
  AST_REJECT_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    (inj_v_i && !inj_status_i[ST_VAL_BIT]) |=> rejected_o); // R2
  AST_REJECT_NO_BANKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (inj_v_i && (cap_i[7:0] == 8'd0)) |=> rejected_o); // R1
  AST_IRQ_GSTAT: assert property (@(posedge clk_i) disable iff (!rst_n)
    inj_v_i |=> (!mce_irq_o || (gstat_q == $past(inj_gstat_i)))); // R6
endmodule

// File: tb/mc_bank_logger_bench.sv
module mc_bank_logger_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cap;
  logic        mce_en;
  logic        cfg_we, cfg_global;
  logic [7:0]  cfg_bank;
  logic [63:0] cfg_data;
  logic        inj_v;
  logic [7:0]  inj_bank;
  logic [63:0] inj_status, inj_gstat, inj_addr, inj_misc;
  logic        inj_uncond;
  logic [2:0]  rd_sel;
  logic [7:0]  rd_bank;
  logic [63:0] rd_data;
  logic        irq, rreq, ign, rej, logd;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mc_bank_logger u_mc_bank_logger (
    .clk_i(clk), .rst_ni(rst_n), .cap_i(cap), .mce_en_i(mce_en),
    .cfg_we_i(cfg_we), .cfg_global_i(cfg_global), .cfg_bank_i(cfg_bank),
    .cfg_data_i(cfg_data), .inj_v_i(inj_v), .inj_bank_i(inj_bank),
    .inj_status_i(inj_status), .inj_gstat_i(inj_gstat), .inj_addr_i(inj_addr),
    .inj_misc_i(inj_misc), .inj_uncond_i(inj_uncond), .rd_sel_i(rd_sel),
    .rd_bank_i(rd_bank), .rd_data_o(rd_data), .mce_irq_o(irq),
    .reset_req_o(rreq), .ignored_o(ign), .rejected_o(rej), .logged_o(logd)
  );

  // outcome codes: 0 none, 1 irq, 2 reset, 3 ignored, 4 rejected, 5 logged, 7 several
  localparam int NV = 8;
  localparam logic [7:0]  V_BANK [NV] = '{8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd2, 8'd3, 8'd4};
  localparam logic [63:0] V_ST   [NV] = '{
    64'h8000_0000_0000_0011, 64'h8000_0000_0000_0044, 64'hA000_0000_0000_0022,
    64'h8000_0000_0000_0055, 64'h8000_0000_0000_0066, 64'hA080_0000_0000_0033,
    64'h2000_0000_0000_0077, 64'h8000_0000_0000_0011};
  localparam logic [63:0] V_GS   [NV] = '{64'h0, 64'h0, 64'h5, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0};
  localparam logic [63:0] V_AD   [NV] = '{64'h100, 64'h200, 64'h300, 64'h400,
                                          64'h500, 64'h600, 64'h700, 64'h800};
  localparam logic        V_UNC  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [2:0]  V_OC   [NV] = '{3'd5, 3'd5, 3'd1, 3'd3, 3'd5, 3'd2, 3'd4, 3'd4};
  localparam logic [63:0] V_EXP  [NV] = '{
    64'h8000_0000_0000_0011, 64'hC000_0000_0000_0044, 64'hA000_0000_0000_0022,
    64'hA000_0000_0000_0022, 64'hE000_0000_0000_0022, 64'h0,
    64'h0, 64'h0};
  string v_req [NV];

  function automatic logic [2:0] oc_now();
    int n;
    logic [2:0] c;
    n = int'(irq) + int'(rreq) + int'(ign) + int'(rej) + int'(logd);
    c = 3'd0;
    if (irq)  c = 3'd1;
    if (rreq) c = 3'd2;
    if (ign)  c = 3'd3;
    if (rej)  c = 3'd4;
    if (logd) c = 3'd5;
    if (n > 1) c = 3'd7;
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, input logic [7:0] bank, output logic [63:0] d);
    rd_sel  = sel;
    rd_bank = bank;
    #1;
    d = rd_data;
  endtask

  task automatic cfg(input logic glob, input logic [7:0] bank, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_global = glob; cfg_bank = bank; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one strobe; returns at the negedge after the capturing edge
  task automatic inject(input logic [7:0] bank, input logic [63:0] st, input logic [63:0] gs,
                        input logic [63:0] ad, input logic unc);
    @(negedge clk);
    inj_v = 1'b1; inj_bank = bank; inj_status = st; inj_gstat = gs;
    inj_addr = ad; inj_misc = ad ^ 64'hFF; inj_uncond = unc;
    @(negedge clk);
    inj_v = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    v_req[0] = "R7"; v_req[1] = "R7"; v_req[2] = "R6"; v_req[3] = "R3";
    v_req[4] = "R8"; v_req[5] = "R5"; v_req[6] = "R2"; v_req[7] = "R1";
    cap = 64'h104; mce_en = 1'b1;
    cfg_we = 1'b0; cfg_global = 1'b0; cfg_bank = '0; cfg_data = '0;
    inj_v = 1'b0; inj_bank = '0; inj_status = '0; inj_gstat = '0;
    inj_addr = '0; inj_misc = '0; inj_uncond = 1'b0; rd_sel = '0; rd_bank = '0;
    do_reset();

    // R9 reset state
    rd(3'd0, 8'd0, d); chk("R9 bank ctl", d, '1);
    rd(3'd1, 8'd3, d); chk("R9 bank status", d, '0);
    rd(3'd4, 8'd0, d); chk("R9 global ctl", d, '1);
    rd(3'd5, 8'd0, d); chk("R9 global status", d, '0);
    chk("R10 idle outputs", 64'(oc_now()), 64'd0);

    for (int i = 0; i < NV; i++) begin
      inject(V_BANK[i], V_ST[i], V_GS[i], V_AD[i], V_UNC[i]);
      chk({v_req[i], " R10 outcome"}, 64'(oc_now()), 64'(V_OC[i]));
      rd(3'd1, V_BANK[i], d);
      chk({v_req[i], " bank status"}, d, V_EXP[i]);
    end
    rd(3'd2, 8'd1, d); chk("R8 address kept", d, 64'h300);
    rd(3'd3, 8'd1, d); chk("R8 misc kept", d, 64'h3FF);
    rd(3'd2, 8'd0, d); chk("R7 address written", d, 64'h200);
    rd(3'd5, 8'd0, d); chk("R6 global status", d, 64'h5);
    @(negedge clk);
    chk("R10 no repeat pulse", 64'(oc_now()), 64'd0);

    do_reset();
    // R5 machine-check disabled
    mce_en = 1'b0;
    inject(8'd0, 64'hA000_0000_0000_0022, 64'h4, 64'h900, 1'b0);
    chk("R5 reset request", 64'(oc_now()), 64'd2);
    rd(3'd1, 8'd0, d); chk("R5 status untouched", d, '0);
    rd(3'd5, 8'd0, d); chk("R5 global untouched", d, '0);
    mce_en = 1'b1;

    // R4 global control gate
    cfg(1'b1, 8'd0, 64'h0);
    rd(3'd4, 8'd0, d); chk("R11 global ctl write", d, 64'h0);
    inject(8'd0, 64'hA000_0000_0000_0022, 64'h1, 64'hA00, 1'b0);
    chk("R4 dropped by global ctl", 64'(oc_now()), 64'd3);
    rd(3'd1, 8'd0, d); chk("R4 status untouched", d, '0);
    cap = 64'h004;
    inject(8'd0, 64'hA000_0000_0000_0022, 64'h1, 64'hB00, 1'b0);
    chk("R4 gate off without ctl-present", 64'(oc_now()), 64'd1);
    rd(3'd1, 8'd0, d); chk("R6 status logged", d, 64'hA000_0000_0000_0022);
    rd(3'd5, 8'd0, d); chk("R6 global written", d, 64'h1);
    rd(3'd6, 8'd0, d); chk("R11 capability read", d, 64'h004);

    // R4 bank control gate
    cap = 64'h104;
    cfg(1'b1, 8'd0, '1);
    cfg(1'b0, 8'd2, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(3'd0, 8'd2, d); chk("R11 bank ctl write", d, 64'hFFFF_FFFF_FFFF_FFFE);
    inject(8'd2, 64'hA000_0000_0000_0022, 64'h0, 64'hC00, 1'b0);
    chk("R4 dropped by bank ctl", 64'(oc_now()), 64'd3);
    rd(3'd1, 8'd2, d); chk("R4 bank status untouched", d, '0);

    // R1 capability limits
    cap = 64'h0;
    inject(8'd0, 64'h8000_0000_0000_0011, 64'h0, 64'hD00, 1'b0);
    chk("R1 zero capability", 64'(oc_now()), 64'd4);
    cap = 64'h102;
    inject(8'd3, 64'h8000_0000_0000_0011, 64'h0, 64'hD00, 1'b0);
    chk("R1 bank beyond count", 64'(oc_now()), 64'd4);
    rd(3'd1, 8'd3, d); chk("R1 state untouched", d, '0);
    rd(3'd1, 8'd9, d); chk("R11 out-of-range read", d, '0);

    // R6 overflow over a valid corrected entry
    cap = 64'h104;
    inject(8'd3, 64'h8000_0000_0000_0011, 64'h0, 64'hE00, 1'b0);
    chk("R7 corrected into empty bank", 64'(oc_now()), 64'd5);
    inject(8'd3, 64'hA000_0000_0000_0022, 64'h0, 64'hF00, 1'b0);
    chk("R6 interrupt", 64'(oc_now()), 64'd1);
    rd(3'd1, 8'd3, d); chk("R6 overflow marked", d, 64'hE000_0000_0000_0022);
    rd(3'd2, 8'd3, d); chk("R6 address written", d, 64'hF00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule